// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block is a master-only synchronous serial transfer unit that moves one 8-bit character per transfer. It generates its own shift clock from the reference clock. Software picks one of six fixed rates with a 3-bit code. The same shift register serves two wiring schemes. With two wires there is a clock and one shared data line, and that line is driven only when the transfer is a transmit. With three wires there is a clock plus a separate output and input, and both move in the same transfer. Each transfer can send either the most or the least significant bit first.

The host writes a byte into a holding register and pulses a start request. It then watches a busy flag, or waits for the completion interrupt request, and reads the received byte. The rate code, bit order, wiring scheme and direction are captured when a transfer starts, so changing them in the middle of a transfer does not disturb it. The shift clock rests high. Output data moves on each falling edge of the shift clock, and input data is taken on each rising edge.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, busy and irqReq are 0, serClk and serOut are 1, rxData is 0 and serOutEn is 0.
- R2: The rateSel codes 0,1,2,3,4,5 give shift-clock periods of 360, 120, 24, 16, 12 and 10 reference cycles. Each half is held for half that count. The first falling edge of serClk comes exactly one half-period after the edge that accepts the start.
- R3: The rateSel codes 6 and 7 are reserved. A start request made with either code is ignored and busy stays 0.
- R4: Every transfer gives exactly 8 low pulses on serClk. serClk is 1 whenever the port is not busy.
- R5: When msbFirst=1 at start, bit 7 of the held byte is sent first, and the first bit received lands in rxData bit 7. When msbFirst=0, bit 0 goes first both ways.
- R6: serOut changes only on the reference edge where serClk falls, or on the completion edge where it returns to 1. The input bit is taken on the edge where serClk rises.
- R7: In three-wire mode (threeWire=1) serOutEn is 1 and input bits come from serInA.
- R8: In two-wire mode (threeWire=0) serOutEn is 1 only while busy with txDir=1, and input bits come from serInB.
- R9: A start request while busy is ignored. A loadEn write while busy leaves the held byte unchanged.
- R10: busy falls and irqReq rises one reference cycle after the eighth input bit is taken. rxData shows the new byte in that same cycle.
- R11: irqAck clears irqReq. If irqAck comes in the same cycle as a completion, irqReq stays set.
- R12: rateSel, msbFirst, threeWire and txDir are captured at start. Changing them during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Write loadData into the transmit holding register |
| loadData | input | 8 | Byte to transmit |
| startReq | input | 1 | Begin a transfer when idle |
| rateSel | input | 3 | Shift-clock rate code (6 and 7 reserved) |
| msbFirst | input | 1 | 1: most significant bit first |
| threeWire | input | 1 | 1: separate in/out lines, 0: shared line |
| txDir | input | 1 | Two-wire mode: 1 transmit, 0 receive |
| irqAck | input | 1 | Clear the completion request |
| busy | output | 1 | Transfer in progress |
| irqReq | output | 1 | Completion interrupt request |
| rxData | output | 8 | Last received byte |
| serClk | output | 1 | Shift clock, idles high |
| serOut | output | 1 | Serial data out |
| serOutEn | output | 1 | Output enable for serOut |
| serInA | input | 1 | Input line for three-wire mode |
| serInB | input | 1 | Shared line read-back for two-wire mode |

## Verification
Completion of a transfer and the host's clear of the interrupt request can land in the same reference cycle. The bench waits until its model reports that the eighth bit has just been taken, then asserts irqAck for exactly the next edge. It expects irqReq to be high afterwards, and a later lone irqAck to drop it. A start request can also arrive during that final cycle, while busy is still high. The bench provokes this and expects the request to be dropped, which the per-cycle comparison of busy and serClk against the model makes visible.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int RATE_W    = 3;
  localparam int NUM_RATES = 6;
  localparam int MAX_HALF  = 180;
  localparam int CNT_W     = $clog2(MAX_HALF);

  typedef struct packed {
    logic load;
    logic fall;
    logic rise;
    logic finish;
  } ssp_strobe_t;

  function automatic logic rateValid(input logic [RATE_W-1:0] code);
    return int'(code) < NUM_RATES;
  endfunction

  function automatic logic [CNT_W-1:0] halfPeriod(input logic [RATE_W-1:0] code);
    logic [CNT_W-1:0] h;
    case (code)
      3'd0:    h = CNT_W'(180);
      3'd1:    h = CNT_W'(60);
      3'd2:    h = CNT_W'(12);
      3'd3:    h = CNT_W'(8);
      3'd4:    h = CNT_W'(6);
      3'd5:    h = CNT_W'(5);
      default: h = CNT_W'(1);
    endcase
    return h;
  endfunction

endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              irqAck,
  output logic              busy,
  output logic              serClk,
  output logic              irqReq,
  output ssp_strobe_t       stb
);

  localparam int BIT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfL;
  logic [BIT_W-1:0] bitCnt;
  logic             finQ;
  logic             startOk;
  logic             edgeDue;

  assign startOk = !busy && startReq && rateValid(rateSel);
  assign edgeDue = busy && !finQ && (cnt == '0);

  always_comb begin
    stb        = '0;
    stb.load   = startOk;
    stb.fall   = edgeDue && serClk;
    stb.rise   = edgeDue && !serClk;
    stb.finish = finQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      serClk <= 1'b1;
      cnt    <= '0;
      halfL  <= '0;
      bitCnt <= '0;
      finQ   <= 1'b0;
    end else if (startOk) begin
      busy   <= 1'b1;
      serClk <= 1'b1;
      halfL  <= halfPeriod(rateSel) - CNT_W'(1);
      cnt    <= halfPeriod(rateSel) - CNT_W'(1);
      bitCnt <= '0;
    end else if (finQ) begin
      busy <= 1'b0;
      finQ <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) begin
        cnt    <= halfL;
        serClk <= !serClk;
        if (!serClk) begin
          bitCnt <= bitCnt + BIT_W'(1);
          if (bitCnt == BIT_W'(DATA_W - 1)) finQ <= 1'b1;
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       irqReq <= 1'b0;
    else if (finQ)   irqReq <= 1'b1;
    else if (irqAck) irqReq <= 1'b0;
  end

endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssp_strobe_t       stb,
  input  logic              busy,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadData,
  input  logic              msbFirst,
  input  logic              threeWire,
  input  logic              txDir,
  input  logic              serInA,
  input  logic              serInB,
  output logic [DATA_W-1:0] rxData,
  output logic              serOut,
  output logic              serOutEn
);

  logic [DATA_W-1:0] txHold;
  logic [DATA_W-1:0] shiftQ;
  logic              msbL;
  logic              threeWireL;
  logic              txDirL;
  logic              inBit;
  logic              headBit;

  assign inBit    = threeWireL ? serInA : serInB;
  assign headBit  = msbL ? shiftQ[DATA_W-1] : shiftQ[0];
  assign serOutEn = busy ? (threeWireL || txDirL) : threeWire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold <= '0;
    end else if (loadEn && !busy) begin
      txHold <= loadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ     <= '0;
      msbL       <= 1'b0;
      threeWireL <= 1'b0;
      txDirL     <= 1'b0;
    end else if (stb.load) begin
      shiftQ     <= txHold;
      msbL       <= msbFirst;
      threeWireL <= threeWire;
      txDirL     <= txDir;
    end else if (stb.rise) begin
      if (msbL) shiftQ <= {shiftQ[DATA_W-2:0], inBit};
      else      shiftQ <= {inBit, shiftQ[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serOut <= 1'b1;
      rxData <= '0;
    end else if (stb.finish) begin
      serOut <= 1'b1;
      rxData <= shiftQ;
    end else if (stb.fall) begin
      serOut <= headBit;
    end
  end

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadData,
  input  logic              startReq,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              msbFirst,
  input  logic              threeWire,
  input  logic              txDir,
  input  logic              irqAck,
  output logic              busy,
  output logic              irqReq,
  output logic [DATA_W-1:0] rxData,
  output logic              serClk,
  output logic              serOut,
  output logic              serOutEn,
  input  logic              serInA,
  input  logic              serInB
);

  ssp_strobe_t stb;

  ssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .rateSel  (rateSel),
    .irqAck   (irqAck),
    .busy     (busy),
    .serClk   (serClk),
    .irqReq   (irqReq),
    .stb      (stb)
  );

  ssp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busy      (busy),
    .loadEn    (loadEn),
    .loadData  (loadData),
    .msbFirst  (msbFirst),
    .threeWire (threeWire),
    .txDir     (txDir),
    .serInA    (serInA),
    .serInB    (serInB),
    .rxData    (rxData),
    .serOut    (serOut),
    .serOutEn  (serOutEn)
  );

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic [2:0] rateSel,
  input logic       irqAck,
  input logic       busy,
  input logic       irqReq,
  input logic       serClk,
  input logic       serOut
);

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serClk);

  // R10
  done_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irqReq);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $fell(busy));

  // R6
  out_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOut) |-> (!serClk || !busy));

  // R9
  start_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  // R3
  reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && rateSel >= 3'd6) |=> !busy);

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqReq) |-> $past(irqAck));

endmodule

bind sync_serial_port ssp_checker u_ssp_checker (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .rateSel  (rateSel),
  .irqAck   (irqAck),
  .busy     (busy),
  .irqReq   (irqReq),
  .serClk   (serClk),
  .serOut   (serOut)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 150000;
  localparam int XFER_LIMIT      = 5000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [7:0] loadData = 8'h00;
  logic       startReq = 1'b0;
  logic [2:0] rateSel = 3'd5;
  logic       msbFirst = 1'b1;
  logic       threeWire = 1'b0;
  logic       txDir = 1'b0;
  logic       irqAck = 1'b0;
  logic       busy, irqReq, serClk, serOut, serOutEn;
  logic [7:0] rxData;
  logic       serInA;
  logic       serInB;
  logic       slaveBit = 1'b0;
  logic [7:0] slaveByte = 8'h00;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign serInA = slaveBit;
  assign serInB = serOutEn ? serOut : slaveBit;

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadData(loadData),
    .startReq(startReq), .rateSel(rateSel), .msbFirst(msbFirst),
    .threeWire(threeWire), .txDir(txDir), .irqAck(irqAck),
    .busy(busy), .irqReq(irqReq), .rxData(rxData), .serClk(serClk),
    .serOut(serOut), .serOutEn(serOutEn), .serInA(serInA), .serInB(serInB)
  );

  // ---------------- reference model ----------------
  bit         mBusy = 0, mIrq = 0, mSclk = 1, mOut = 1, mFin = 0;
  bit         mMsb = 0, mTw = 0, mTx = 0;
  int         mE = 0, mH = 1;
  logic [7:0] mHold = 8'h00, mRx = 8'h00;
  bit         mTxBits[$];
  bit         mRxBits[$];

  function automatic int halfOf(input int code);
    int quarterHz[6] = '{50000, 150000, 750000, 1125000, 1500000, 1800000};
    return (18000000 / quarterHz[code]) / 2;
  endfunction

  always @(posedge clk) begin
    bit wasBusy, wasFin, inB;
    int p;
    wasBusy = mBusy;
    wasFin  = mFin;
    inB     = mTw ? serInA : serInB;
    if (!rstN) begin
      mBusy = 0; mIrq = 0; mSclk = 1; mOut = 1; mFin = 0;
      mMsb = 0; mTw = 0; mTx = 0; mE = 0; mH = 1;
      mHold = 8'h00; mRx = 8'h00;
      mTxBits.delete(); mRxBits.delete();
    end else begin
      if (wasFin) begin
        mBusy = 0; mFin = 0; mOut = 1;
        for (int k = 0; k < 8; k++) begin
          if (mMsb) mRx[7-k] = mRxBits[k];
          else      mRx[k]   = mRxBits[k];
        end
      end else if (wasBusy) begin
        mE++;
        if (mE % mH == 0) begin
          p = mE / mH;
          if (p % 2 == 1) begin
            mSclk = 0;
            mOut  = mTxBits[(p-1)/2];
          end else begin
            mSclk = 1;
            mRxBits.push_back(inB);
            if (p == 16) mFin = 1;
          end
        end
      end else if (startReq && rateSel < 3'd6) begin
        mBusy = 1; mE = 0; mH = halfOf(int'(rateSel)); mSclk = 1;
        mMsb = msbFirst; mTw = threeWire; mTx = txDir;
        mTxBits.delete(); mRxBits.delete();
        for (int k = 0; k < 8; k++) mTxBits.push_back(msbFirst ? mHold[7-k] : mHold[k]);
      end
      if (wasFin)      mIrq = 1;
      else if (irqAck) mIrq = 0;
      if (loadEn && !wasBusy) mHold = loadData;
    end
  end

  // slave presents the next bit away from the active edge
  always @(negedge clk) begin
    int idx;
    idx = mRxBits.size();
    if (idx < 8) slaveBit = slaveByte[mMsb ? 7 - idx : idx];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit expOe;
    if (rstN && !done) begin
      expOe = mBusy ? (mTw || mTx) : threeWire;
      check(busy == mBusy,     "R10 busy",          busy,     mBusy);
      check(irqReq == mIrq,    "R11 irqReq",        irqReq,   mIrq);
      check(serClk == mSclk,   "R2 R4 serClk",      serClk,   mSclk);
      check(serOut == mOut,    "R5 R6 serOut",      serOut,   mOut);
      check(serOutEn == expOe, "R7 R8 serOutEn",    serOutEn, expOe);
      check(rxData == mRx,     "R5 R10 rxData",     rxData,   mRx);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < XFER_LIMIT) begin cyc(1); n++; end
    if (n >= XFER_LIMIT) check(0, "R10 transfer hung", busy, 0);
  endtask

  task automatic loadByte(input logic [7:0] b);
    loadEn = 1; loadData = b; cyc(1); loadEn = 0;
  endtask

  task automatic startXfer(input logic [2:0] rate, input bit msb, input bit tw, input bit dir);
    rateSel = rate; msbFirst = msb; threeWire = tw; txDir = dir;
    startReq = 1; cyc(1); startReq = 0;
  endtask

  task automatic finishUp();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finishUp();
  end

  initial begin
    int n;
    cyc(3);
    rstN = 1;
    cyc(1);
    // R1 reset state
    check(busy == 0 && irqReq == 0 && serClk == 1 && serOut == 1, "R1 reset outputs",
          {busy, irqReq, serClk, serOut}, 4'b0011);
    check(rxData == 8'h00 && serOutEn == 0, "R1 reset data/enable", {rxData, serOutEn}, 0);

    // R7 R5: three-wire, MSB first
    slaveByte = 8'h3C; loadByte(8'hA5);
    startXfer(3'd5, 1, 1, 0);
    waitIdle();
    check(rxData == 8'h3C, "R5 R7 msb-first three-wire rx", rxData, 8'h3C);
    check(irqReq == 1, "R10 irq after completion", irqReq, 1);
    irqAck = 1; cyc(1); irqAck = 0;
    check(irqReq == 0, "R11 ack clears irq", irqReq, 0);

    // R5: LSB first
    slaveByte = 8'h81; loadByte(8'h0F);
    startXfer(3'd4, 0, 1, 0);
    waitIdle();
    check(rxData == 8'h81, "R5 lsb-first rx", rxData, 8'h81);

    // R8: two-wire transmit with read-back, then two-wire receive
    loadByte(8'hC6);
    startXfer(3'd3, 1, 0, 1);
    cyc(5);
    check(serOutEn == 1, "R8 drive while transmitting", serOutEn, 1);
    waitIdle();
    check(rxData == 8'hC6, "R8 two-wire read-back", rxData, 8'hC6);
    check(serOutEn == 0, "R8 released when idle", serOutEn, 0);
    slaveByte = 8'h6B;
    startXfer(3'd2, 0, 0, 0);
    cyc(5);
    check(serOutEn == 0, "R8 released while receiving", serOutEn, 0);
    waitIdle();
    check(rxData == 8'h6B, "R8 two-wire rx from serInB", rxData, 8'h6B);

    // R2: half-period of every rate
    for (int r = 0; r < 6; r++) begin
      slaveByte = 8'h55;
      startXfer(3'(r), 1, 1, 0);
      n = 0;
      while (serClk && n < 400) begin cyc(1); n++; end
      check(n == halfOf(r), $sformatf("R2 half period code %0d", r), n, halfOf(r));
      waitIdle();
    end

    // R3: reserved codes
    for (int r = 6; r < 8; r++) begin
      startXfer(3'(r), 1, 1, 0);
      cyc(3);
      check(busy == 0, $sformatf("R3 reserved code %0d ignored", r), busy, 0);
    end

    // R9 R12: load/start/config change while busy
    loadByte(8'h5A);
    startXfer(3'd5, 1, 0, 1);
    cyc(7);
    loadEn = 1; loadData = 8'hFF; msbFirst = 0; txDir = 0; rateSel = 3'd0;
    startReq = 1; cyc(1); loadEn = 0; startReq = 0;
    check(busy == 1, "R9 still busy after mid start", busy, 1);
    waitIdle();
    check(rxData == 8'h5A, "R12 config latched at start", rxData, 8'h5A);
    startXfer(3'd5, 1, 0, 1);
    waitIdle();
    check(rxData == 8'h5A, "R9 load while busy ignored", rxData, 8'h5A);

    // R11: ack coinciding with completion, plus start in final cycle
    irqAck = 1; cyc(1); irqAck = 0;
    slaveByte = 8'h96;
    startXfer(3'd5, 1, 1, 0);
    n = 0;
    while (!mFin && n < XFER_LIMIT) begin cyc(1); n++; end
    irqAck = 1; startReq = 1; cyc(1); irqAck = 0; startReq = 0;
    check(irqReq == 1, "R11 completion wins over ack", irqReq, 1);
    check(busy == 0, "R9 start in final cycle ignored", busy, 0);
    check(rxData == 8'h96, "R10 rx with completion", rxData, 8'h96);
    irqAck = 1; cyc(1); irqAck = 0;
    check(irqReq == 0, "R11 lone ack clears", irqReq, 0);

    cyc(4);
    finishUp();
  end

endmodule